// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block is the host-side gateway for configuration accesses to a bus of up to 32 peripheral device slots. It sits on a simple I/O-port bus that carries a 16-bit port address, an access size of 1, 2 or 4 bytes, write data and separate read and write strobes. One port holds a 32-bit address latch. That latch is split into an enable bit, a bus number, a device number, a function number and a register offset. Accesses to a group of four data ports become configuration requests toward the device slots. Each request uses a valid/ready handshake.

The block also contains three small side functions. The first is a reset-control port, which raises a one-cycle reset request marked as hard or soft. The second and third are two edge/level control bytes. Each byte has a fixed mask of writable bits, and each pulses an update output when its stored value changes. Every access is accepted in a single cycle. A read answers with a registered valid one cycle later. For a forwarded read, that cycle is the one after the slot completes the handshake.

Top module: `cfg_port_decoder`

## Requirements
- R1: A write of any accepted size to port 0xCF8 stores all 32 bits of `io_wdata` in the address latch. A read of 0xCF8 returns the latch, masked to the access size.
- R2: The latch decodes as follows: bit 31 is enable, bits 23:16 are bus, bits 15:11 are device and bits 10:8 are function. An access to ports 0xCFC–0xCFF is forwarded only when all of these hold: enable is 1, function is 0, bus is 0, and `slot_present[device]` is 1. A forwarded request carries `cfg_dev` = device, `cfg_reg` = {latch[7:2], port[1:0]}, the access size, the write data and `cfg_write`.
- R3: `cfg_valid` rises one cycle after the accepted data-port strobe. It holds with stable request fields until the cycle in which `cfg_ready` is high. `io_busy` equals the pending state, and I/O strobes that arrive while it is high are ignored.
- R4: A forwarded read completes with `io_rvalid` high for one cycle, one cycle after the handshake cycle. `io_rdata` then equals `cfg_rdata` masked to the size: 0xFF for 1, 0xFFFF for 2 and 0xFFFFFFFF for 4.
- R5: A data-port read with enable set and function 0, but with a nonzero bus or an absent slot, issues no request and raises no error. It returns all-ones masked to the size, with `io_rvalid` one cycle later. A write of the same kind is dropped.
- R6: A data-port access with enable clear or a nonzero function issues no request. It pulses `io_err` one cycle later, and a read returns all-ones masked to the size.
- R7: Port 0x4D0 stores `wdata[7:0] & 0xF8` in `lvl_mask0`, and port 0x4D1 stores `wdata[7:0] & 0xDE` in `lvl_mask1`. Each is readable back. `lvl_upd[0]` or `lvl_upd[1]` pulses one cycle after a write only if the stored value changed.
- R8: A write to port 0xCF9 sets the hard-reset flag `rst_hard` from data bit 1. If data bit 2 is set, `rst_req` pulses one cycle later. A read of 0xCF9 returns the flag in bit 1 and zeros elsewhere.
- R9: A size other than 1, 2 or 4, or a port outside the set above, pulses `io_err` one cycle later and changes no state. A read of this kind still gets `io_rvalid` with all-ones masked to the size, or the full 32 bits if the size is invalid.
- R10: After reset, the latch, both level bytes and the reset flag are zero, and every output strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe (takes priority over read) |
| io_addr | input | 16 | I/O port address |
| io_size | input | 3 | Access size in bytes |
| io_wdata | input | 32 | I/O write data |
| io_rdata | output | 32 | Registered read data |
| io_rvalid | output | 1 | Read data valid, one cycle |
| io_err | output | 1 | Access error pulse |
| io_busy | output | 1 | Configuration request pending |
| slot_present | input | 32 | One bit per populated device slot |
| cfg_valid | output | 1 | Configuration request valid |
| cfg_ready | input | 1 | Slot accepts request |
| cfg_write | output | 1 | Request is a write |
| cfg_dev | output | 5 | Target device slot |
| cfg_reg | output | 8 | Byte offset in configuration space |
| cfg_size | output | 3 | Request size in bytes |
| cfg_wdata | output | 32 | Request write data |
| cfg_rdata | input | 32 | Slot read data, valid in the handshake cycle |
| lvl_mask0 | output | 8 | First edge/level control byte |
| lvl_mask1 | output | 8 | Second edge/level control byte |
| lvl_upd | output | 2 | Change pulse per control byte |
| rst_req | output | 1 | Reset request pulse |
| rst_hard | output | 1 | Reset type flag, 1 means hard |

## Verification
A seeded random mix of latch values spans every gating case. These are enable on or off, function zero or nonzero, bus zero or nonzero, and present or absent slots. Each case is paired with every byte lane and all three sizes, so the forwarded offset and the size mask are separated from the all-ones fallback and the error path. Random slot response delays show that the request fields hold until the handshake. A held-off handshake with a latch write in the middle shows that strobes arriving while busy are dropped. Directed writes to the level bytes repeat the same value so that a changed write can be told apart from an unchanged one by the update pulse. Reset-port writes combine bits 1 and 2 to separate the flag from the request.

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [2:0]  io_size,
  input  logic [31:0] io_wdata,
  output logic [31:0] io_rdata,
  output logic        io_rvalid,
  output logic        io_err,
  output logic        io_busy,
  input  logic [31:0] slot_present,
  output logic        cfg_valid,
  input  logic        cfg_ready,
  output logic        cfg_write,
  output logic [4:0]  cfg_dev,
  output logic [7:0]  cfg_reg,
  output logic [2:0]  cfg_size,
  output logic [31:0] cfg_wdata,
  input  logic [31:0] cfg_rdata,
  output logic [7:0]  lvl_mask0,
  output logic [7:0]  lvl_mask1,
  output logic [1:0]  lvl_upd,
  output logic        rst_req,
  output logic        rst_hard
);

  logic [31:0] latch;
  logic        pend;

  function automatic logic [31:0] szmask(input logic [2:0] s);
    case (s)
      3'd1:    szmask = 32'h0000_00FF;
      3'd2:    szmask = 32'h0000_FFFF;
      default: szmask = 32'hFFFF_FFFF;
    endcase
  endfunction

  wire acc     = (io_rd | io_wr) & ~pend;
  wire size_ok = (io_size == 3'd1) | (io_size == 3'd2) | (io_size == 3'd4);
  wire p_adr   = io_addr == 16'h0CF8;
  wire p_rst   = io_addr == 16'h0CF9;
  wire p_lv0   = io_addr == 16'h04D0;
  wire p_lv1   = io_addr == 16'h04D1;
  wire p_dat   = io_addr[15:2] == 14'h033F;
  wire bad     = ~size_ok | ~(p_adr | p_rst | p_lv0 | p_lv1 | p_dat);
  wire blocked = ~latch[31] | (latch[10:8] != 3'd0);
  wire slot_ok = (latch[23:16] == 8'd0) & slot_present[latch[15:11]];
  wire fwd     = p_dat & ~bad & ~blocked & slot_ok;
  wire [7:0] lv0_n = io_wdata[7:0] & 8'hF8;
  wire [7:0] lv1_n = io_wdata[7:0] & 8'hDE;

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = 32'hFFFF_FFFF;
    if (!bad && !p_dat) begin
      if (p_adr)      rd_mux = latch;
      else if (p_rst) rd_mux = {30'd0, rst_hard, 1'b0};
      else if (p_lv0) rd_mux = {24'd0, lvl_mask0};
      else            rd_mux = {24'd0, lvl_mask1};
    end
  end

  assign io_busy   = pend;
  assign cfg_valid = pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch <= '0; pend <= 1'b0; cfg_write <= 1'b0; cfg_dev <= '0;
      cfg_reg <= '0; cfg_size <= '0; cfg_wdata <= '0;
      io_rdata <= '0; io_rvalid <= 1'b0; io_err <= 1'b0;
      lvl_mask0 <= '0; lvl_mask1 <= '0; lvl_upd <= '0;
      rst_req <= 1'b0; rst_hard <= 1'b0;
    end else begin
      io_rvalid <= 1'b0;
      io_err    <= 1'b0;
      lvl_upd   <= 2'b00;
      rst_req   <= 1'b0;
      if (pend && cfg_ready) begin
        pend <= 1'b0;
        if (!cfg_write) begin
          io_rdata  <= cfg_rdata & szmask(cfg_size);
          io_rvalid <= 1'b1;
        end
      end
      if (acc) begin
        io_err <= bad | (p_dat & blocked);
        if (fwd) begin
          pend      <= 1'b1;
          cfg_write <= io_wr;
          cfg_dev   <= latch[15:11];
          cfg_reg   <= {latch[7:2], io_addr[1:0]};
          cfg_size  <= io_size;
          cfg_wdata <= io_wdata;
        end else if (!io_wr) begin
          io_rdata  <= rd_mux & szmask(io_size);
          io_rvalid <= 1'b1;
        end
        if (io_wr && !bad) begin
          if (p_adr) latch <= io_wdata;
          if (p_rst) begin
            rst_hard <= io_wdata[1];
            rst_req  <= io_wdata[2];
          end
          if (p_lv0 && lv0_n != lvl_mask0) begin
            lvl_mask0  <= lv0_n;
            lvl_upd[0] <= 1'b1;
          end
          if (p_lv1 && lv1_n != lvl_mask1) begin
            lvl_mask1  <= lv1_n;
            lvl_upd[1] <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/cfg_port_decoder_chk.sv
module cfg_port_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        io_rd,
  input logic        io_wr,
  input logic [15:0] io_addr,
  input logic [31:0] io_wdata,
  input logic        io_rvalid,
  input logic        io_err,
  input logic        io_busy,
  input logic        cfg_valid,
  input logic        cfg_ready,
  input logic        cfg_write,
  input logic [4:0]  cfg_dev,
  input logic [7:0]  cfg_reg,
  input logic [7:0]  lvl_mask0,
  input logic [7:0]  lvl_mask1,
  input logic        rst_req
);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_reg) && $stable(cfg_dev) && $stable(cfg_write));

  p_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_valid) |-> cfg_reg[1:0] == $past(io_addr[1:0]) && $past(io_addr[15:2]) == 14'h033F);

  p_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_ready && !cfg_write |=> io_rvalid);

  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_mask0 & 8'h07) == 8'h00 && (lvl_mask1 & 8'h21) == 8'h00);

  p_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(io_wr && !io_busy && io_addr == 16'h0CF9 && io_wdata[2]));

  p_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    io_err |-> $past((io_rd || io_wr) && !io_busy));

endmodule

bind cfg_port_decoder cfg_port_decoder_chk chk (
  .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr),
  .io_wdata(io_wdata), .io_rvalid(io_rvalid), .io_err(io_err), .io_busy(io_busy),
  .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_write(cfg_write),
  .cfg_dev(cfg_dev), .cfg_reg(cfg_reg), .lvl_mask0(lvl_mask0),
  .lvl_mask1(lvl_mask1), .rst_req(rst_req)
);

// File: tb/cfg_port_decoder_test.sv
module cfg_port_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_rd = 1'b0, io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [2:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic io_rvalid, io_err, io_busy;
  logic [31:0] slot_present = 32'h8000_0013;
  logic cfg_valid, cfg_write;
  logic cfg_ready = 1'b0;
  logic [4:0] cfg_dev;
  logic [7:0] cfg_reg;
  logic [2:0] cfg_size;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [7:0] lvl_mask0, lvl_mask1;
  logic [1:0] lvl_upd;
  logic rst_req, rst_hard;

  int tests = 0, fails = 0;
  int req_cnt = 0, dly = 0;
  bit hold = 0;
  logic [7:0] r_reg; logic [4:0] r_dev; logic r_wr; logic [31:0] r_wd; logic [2:0] r_sz;
  logic [31:0] a_rd; logic a_rv, a_err, a_rst; logic [1:0] a_upd;

  always #10 clk = ~clk;

  cfg_port_decoder uut (.*);

  function automatic logic [31:0] slot_data(input logic [4:0] d, input logic [7:0] r);
    return {8'hC0, 3'b000, d, r, 8'h5A};
  endfunction
  function automatic logic [31:0] msk(input logic [2:0] s);
    return s == 3'd1 ? 32'hFF : s == 3'd2 ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  assign cfg_rdata = slot_data(cfg_dev, cfg_reg);

  always @(negedge clk) begin
    if (cfg_valid && !cfg_ready && !hold) begin
      if (dly == 0) begin
        cfg_ready = 1'b1;
        r_reg = cfg_reg; r_dev = cfg_dev; r_wr = cfg_write; r_wd = cfg_wdata; r_sz = cfg_size;
        req_cnt++;
      end else dly--;
    end else begin
      cfg_ready = 1'b0;
      dly = $urandom % 4;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic io(input logic wr, input logic [15:0] a, input logic [2:0] s, input logic [31:0] d);
    int n = 0;
    @(negedge clk);
    io_wr = wr; io_rd = ~wr; io_addr = a; io_size = s; io_wdata = d;
    @(negedge clk);
    io_wr = 0; io_rd = 0;
    a_err = io_err; a_upd = lvl_upd; a_rst = rst_req;
    while (io_busy && n < 50) begin @(negedge clk); n++; end
    a_rv = io_rvalid; a_rd = io_rdata;
  endtask

  initial begin
    #2000000;
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int pre;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R10 latch/lvl/flag", {lvl_mask0, lvl_mask1, 7'd0, rst_hard, 7'd0, rst_req}, 32'h0);
    check("R10 strobes", {io_rvalid, io_err, cfg_valid, lvl_upd}, 32'h0);
    rst_n = 1'b1;
    io(0, 16'h0CF8, 3'd4, 0);
    check("R10 latch read", a_rd, 32'h0);

    io(1, 16'h0CF8, 3'd1, 32'h8001_2345);
    io(0, 16'h0CF8, 3'd4, 0);
    check("R1 full write", a_rd, 32'h8001_2345);
    io(0, 16'h0CF8, 3'd2, 0);
    check("R1 word read", a_rd, 32'h2345);

    for (int i = 0; i < 80; i++) begin
      logic [31:0] lat; logic [1:0] ln; logic [2:0] sz; logic [31:0] ex; logic blk, ok;
      lat = {1'b0, 7'd0, 8'd0, 5'd0, 3'd0, 8'd0};
      lat[31] = ($urandom % 6) != 0;
      lat[23:16] = ($urandom % 5) == 0 ? 8'd3 : 8'd0;
      lat[15:11] = ($urandom % 2) ? 5'd31 : 5'($urandom % 6);
      lat[10:8] = ($urandom % 6) == 0 ? 3'd2 : 3'd0;
      lat[7:0] = 8'($urandom);
      ln = 2'($urandom); sz = ($urandom % 3) == 0 ? 3'd1 : (($urandom % 2) ? 3'd2 : 3'd4);
      io(1, 16'h0CF8, 3'd4, lat);
      blk = !lat[31] || lat[10:8] != 0;
      ok  = !blk && lat[23:16] == 0 && slot_present[lat[15:11]];
      pre = req_cnt;
      io(0, {14'h033F, ln}, sz, 0);
      ex = ok ? slot_data(lat[15:11], {lat[7:2], ln}) & msk(sz) : msk(sz);
      check(ok ? "R4 fwd read data" : (blk ? "R6 blocked read" : "R5 absent read"), a_rd, ex);
      check("R2 forwarded iff gated", req_cnt - pre, ok ? 1 : 0);
      check("R6 error flag", a_err, blk);
      if (ok) check("R2 offset", r_reg, {lat[7:2], ln});
    end

    io(1, 16'h0CF8, 3'd4, 32'h8000_0824);
    pre = req_cnt;
    io(1, 16'h0CFE, 3'd2, 32'hDEAD_BEEF);
    check("R2 write req", {r_wr, r_dev, r_reg, r_sz}, {1'b1, 5'd1, 8'h26, 3'd2});
    check("R2 write data", r_wd, 32'hDEAD_BEEF);
    check("R2 write no rvalid", a_rv, 0);
    io(1, 16'h0CF8, 3'd4, 32'h8000_1024);
    pre = req_cnt;
    io(1, 16'h0CFC, 3'd4, 32'h1);
    check("R5 absent write dropped", req_cnt - pre, 0);

    io(1, 16'h0CF8, 3'd4, 32'h8000_0040);
    hold = 1;
    @(negedge clk);
    io_rd = 1; io_addr = 16'h0CFD; io_size = 3'd1;
    @(negedge clk);
    io_rd = 0; io_wr = 1; io_addr = 16'h0CF8; io_size = 3'd4; io_wdata = 32'h1111_1111;
    @(negedge clk);
    io_wr = 0;
    check("R3 busy held", {io_busy, cfg_valid}, 2'b11);
    repeat (3) @(negedge clk);
    check("R3 stable reg", cfg_reg, 8'h41);
    hold = 0;
    while (io_busy) @(negedge clk);
    check("R4 held read", {io_rvalid, io_rdata}, {1'b1, slot_data(5'd0, 8'h41) & 32'hFF});
    io(0, 16'h0CF8, 3'd4, 0);
    check("R3 strobe ignored while busy", a_rd, 32'h8000_0040);

    io(1, 16'h04D0, 3'd1, 32'hFF);
    check("R7 upd0 on change", a_upd, 2'b01);
    io(1, 16'h04D0, 3'd1, 32'hFF);
    check("R7 no upd same", a_upd, 2'b00);
    io(0, 16'h04D0, 3'd1, 0);
    check("R7 mask0 read", a_rd, 32'hF8);
    io(1, 16'h04D1, 3'd1, 32'hFF);
    check("R7 upd1", a_upd, 2'b10);
    io(0, 16'h04D1, 3'd4, 0);
    check("R7 mask1 read", a_rd, 32'hDE);

    io(1, 16'h0CF9, 3'd1, 32'h2);
    check("R8 flag only, no req", {a_rst, rst_hard}, 2'b01);
    io(0, 16'h0CF9, 3'd1, 0);
    check("R8 read flag", a_rd, 32'h2);
    io(1, 16'h0CF9, 3'd1, 32'h4);
    check("R8 soft req", {a_rst, rst_hard}, 2'b10);
    io(1, 16'h0CF9, 3'd1, 32'h6);
    check("R8 hard req", {a_rst, rst_hard}, 2'b11);

    io(1, 16'h0CF8, 3'd3, 32'h0);
    check("R9 bad size err", a_err, 1);
    io(0, 16'h0CF8, 3'd4, 0);
    check("R9 bad size no change", a_rd, 32'h8000_0040);
    io(0, 16'hAE0C, 3'd2, 0);
    check("R9 unknown port", {a_err, a_rv, a_rd}, {2'b11, 32'hFFFF});
    io(1, 16'h04D2, 3'd1, 32'h0);
    check("R9 unknown write err", a_err, 1);
    io(0, 16'h04D0, 3'd1, 0);
    check("R9 lvl unchanged / R10 rd byte", a_rd, 32'hF8);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule